// File: doc/BRIEF.md
# Single-Pin GPIO Cell with Interrupt Detection

This block is one general-purpose I/O pin together with its own 32-bit control and status word. The pin input passes through a synchronizer, and the synchronized level can be read back. The pin output is driven only when software has enabled the output. An interrupt detector watches the synchronized input. Software chooses between level and edge triggering and sets a two-bit polarity. A detected event sets a sticky status flag, and the cell raises its interrupt request only when both detection and delivery are enabled.

Software accesses the cell through one register with a write strobe and a combinational read word. To clear the status flag, software writes the word back with the status bit set to one. This lets an interrupt handler acknowledge the event by writing back the value it just read. Other cells of the same kind can be tiled to make a bank. Each cell is independent.

Top module: `gpio_irq_cell`

## Requirements
- R1: While `rst` is high and on the first read after it, `rd_data` is all zeros, `irq` is low and `pin_oe` is low.
- R2: Bit 16 of `rd_data` shows `pin_in` after two clock edges of synchronization. A value written to bit 16 has no effect.
- R3: Bit 23 is the output enable and bit 22 the output value. `pin_oe` equals bit 23. `pin_out` equals bit 22 while bit 23 is set and is 0 otherwise.
- R4: With bit 8 = 0 (edge mode), polarity bits 10:9 select the edge. 00 is rising, 01 is falling, and 10 or 11 is either edge. A qualifying pin change shows in bit 28 three clock edges after `pin_in` changes, and no earlier.
- R5: With bit 8 = 1 (level mode), polarity 00 triggers on a high level, 01 on a low level, and 10 or 11 on any level. If the active level is still present after a clear, bit 28 sets again on the following edge.
- R6: Bit 11 is the detection enable. While it is 0, bit 28 is never set, and an already-set bit 28 keeps its value.
- R7: Bit 28 is sticky. A write with bit 28 = 1 clears it on that edge, and the clear wins over a detection in the same cycle. A write with bit 28 = 0 leaves it unchanged.
- R8: `irq` is high exactly when bit 28, bit 11 and bit 12 (delivery enable) are all set.
- R9: Bits 8 to 12, 22 and 23 read back as written. All bits other than 8-12, 16, 22, 23 and 28 ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control and status word |
| pin_in | input | 1 | Asynchronous pin input |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Gated interrupt request |

## Verification
The assertions check several rules on every cycle:
- `irq` is gated by the three status and enable bits.
- Reserved bits read as zero.
- The pin output follows its enable.
- The status flag stays set until it is cleared by a write.
- A clear write wins over a detection in the same cycle.
- The status flag never rises without a prior detection enable.

The trigger behaviour can only be shown by the bench's scenarios. This covers:
- each polarity in edge and level mode;
- the three-edge latency from pin change to status;
- the one-shot nature of an edge;
- re-arming of a held level after a clear;
- the latency of the synchronized pin readback.

// File: rtl/gpio_cell_pkg.sv
package gpio_cell_pkg;

    localparam int WORD_W     = 32;

    // Bit positions inside the control and status word
    localparam int BIT_LVL    = 8;
    localparam int BIT_POL_LO = 9;
    localparam int BIT_POL_HI = 10;
    localparam int BIT_DET    = 11;
    localparam int BIT_DLV    = 12;
    localparam int BIT_PIN    = 16;
    localparam int BIT_OVAL   = 22;
    localparam int BIT_OEN    = 23;
    localparam int BIT_STS    = 28;

    // Bits that may read back non-zero
    localparam logic [WORD_W-1:0] RD_MASK =
        (WORD_W'(1) << BIT_LVL)  | (WORD_W'(1) << BIT_POL_LO) |
        (WORD_W'(1) << BIT_POL_HI) | (WORD_W'(1) << BIT_DET) |
        (WORD_W'(1) << BIT_DLV)  | (WORD_W'(1) << BIT_PIN) |
        (WORD_W'(1) << BIT_OVAL) | (WORD_W'(1) << BIT_OEN) |
        (WORD_W'(1) << BIT_STS);

    typedef enum logic [1:0] {
        POL_HIGH     = 2'b00,
        POL_LOW      = 2'b01,
        POL_BOTH     = 2'b10,
        POL_BOTH_ALT = 2'b11
    } pol_e;

    typedef struct packed {
        logic lvl;
        pol_e pol;
        logic det_en;
        logic dlv_en;
        logic out_val;
        logic out_en;
    } cell_cfg_t;

    typedef struct packed {
        logic cur;
        logic prev;
    } pin_smp_t;

    function automatic cell_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        cell_cfg_t c;
        c.lvl     = w[BIT_LVL];
        c.pol     = pol_e'({w[BIT_POL_HI], w[BIT_POL_LO]});
        c.det_en  = w[BIT_DET];
        c.dlv_en  = w[BIT_DLV];
        c.out_val = w[BIT_OVAL];
        c.out_en  = w[BIT_OEN];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] word_from_state(input cell_cfg_t c,
                                                          input logic pin,
                                                          input logic sts);
        logic [WORD_W-1:0] w;
        w             = '0;
        w[BIT_LVL]    = c.lvl;
        w[BIT_POL_LO] = c.pol[0];
        w[BIT_POL_HI] = c.pol[1];
        w[BIT_DET]    = c.det_en;
        w[BIT_DLV]    = c.dlv_en;
        w[BIT_PIN]    = pin;
        w[BIT_OVAL]   = c.out_val;
        w[BIT_OEN]    = c.out_en;
        w[BIT_STS]    = sts;
        return w;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
    import gpio_cell_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_in,
    output pin_smp_t smp
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain[LAST];
    end

    assign smp.cur  = chain[LAST];
    assign smp.prev = prev_q;

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_cell_pkg::*;
(
    input  cell_cfg_t cfg,
    input  pin_smp_t  smp,
    output logic      hit
);

    logic rise;
    logic fall;
    logic act;

    always_comb begin
        rise = smp.cur & ~smp.prev;
        fall = ~smp.cur & smp.prev;
        case (cfg.pol)
            POL_HIGH: act = cfg.lvl ? smp.cur  : rise;
            POL_LOW:  act = cfg.lvl ? ~smp.cur : fall;
            default:  act = cfg.lvl ? 1'b1     : (rise | fall);
        endcase
        hit = act & cfg.det_en;
    end

endmodule

// File: rtl/gpio_cell_regs.sv
module gpio_cell_regs
    import gpio_cell_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              hit,
    output cell_cfg_t         cfg,
    output logic              sts
);

    logic clr;

    assign clr = wr_en & wr_data[BIT_STS];

    always_ff @(posedge clk) begin
        if (rst)        cfg <= '0;
        else if (wr_en) cfg <= cfg_from_word(wr_data);
    end

    // A clear write takes priority over a detection in the same cycle
    always_ff @(posedge clk) begin
        if (rst)      sts <= 1'b0;
        else if (clr) sts <= 1'b0;
        else if (hit) sts <= 1'b1;
    end

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
    import gpio_cell_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq
);

    pin_smp_t  smp;
    cell_cfg_t cfg;
    logic      hit;
    logic      sts;

    gpio_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .smp    (smp)
    );

    gpio_trig_detect i_trig (
        .cfg (cfg),
        .smp (smp),
        .hit (hit)
    );

    gpio_cell_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .hit     (hit),
        .cfg     (cfg),
        .sts     (sts)
    );

    assign rd_data = word_from_state(cfg, smp.cur, sts);
    assign pin_oe  = cfg.out_en;
    assign pin_out = cfg.out_en & cfg.out_val;
    assign irq     = sts & cfg.det_en & cfg.dlv_en;

endmodule

// File: rtl/gpio_irq_cell_chk.sv
module gpio_irq_cell_chk
    import gpio_cell_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_clr,
    input logic [WORD_W-1:0] rd_data,
    input logic              pin_out,
    input logic              pin_oe,
    input logic              irq
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && !irq && !pin_oe));

    assert_oe_follows_R3: assert property (@(posedge clk) disable iff (rst)
        pin_oe == rd_data[BIT_OEN]);

    assert_quiet_pin_R3: assert property (@(posedge clk) disable iff (rst)
        !pin_oe |-> !pin_out);

    assert_det_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[BIT_STS]) |-> $past(rd_data[BIT_DET]));

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_clr) |=> !rd_data[BIT_STS]);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_data[BIT_STS] && !(wr_en && wr_clr)) |=> rd_data[BIT_STS]);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        irq == (rd_data[BIT_STS] && rd_data[BIT_DET] && rd_data[BIT_DLV]));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~RD_MASK) == '0);

endmodule

bind gpio_irq_cell gpio_irq_cell_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_clr  (wr_data[gpio_cell_pkg::BIT_STS]),
    .rd_data (rd_data),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq)
);

// File: tb/test_gpio_irq_cell.sv
`timescale 1ns/1ps
module test_gpio_irq_cell;

    localparam real HALF = 2.5;

    localparam logic [31:0] LVL  = 32'h0000_0100;
    localparam logic [31:0] PLO  = 32'h0000_0200;
    localparam logic [31:0] PBO  = 32'h0000_0400;
    localparam logic [31:0] DET  = 32'h0000_0800;
    localparam logic [31:0] DLV  = 32'h0000_1000;
    localparam logic [31:0] STS  = 32'h1000_0000;

    // {write word, expected readback, expected pin_oe, expected pin_out}
    localparam int NVEC = 8;
    localparam logic [65:0] VEC [NVEC] = '{
        {32'hFFFF_FFFF, 32'h00C0_1F00, 1'b1, 1'b1},
        {32'h1000_0000, 32'h0000_0000, 1'b0, 1'b0},
        {32'h0001_0000, 32'h0000_0000, 1'b0, 1'b0},
        {32'h00C0_0000, 32'h00C0_0000, 1'b1, 1'b1},
        {32'h0040_0000, 32'h0040_0000, 1'b0, 1'b0},
        {32'hEF3E_E0FF, 32'h0000_0000, 1'b0, 1'b0},
        {32'h0000_0500, 32'h0000_0500, 1'b0, 1'b0},
        {32'h0080_0000, 32'h0080_0000, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pin_in = 1'b0;
    logic        pin_out;
    logic        pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(HALF) clk = ~clk;

    gpio_irq_cell i_gpio_irq_cell (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq     (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic setpin(input logic v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(HALF * 2 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(4);
        chk("R1 reset word", rd_data, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 pin_oe", {31'b0, pin_oe}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 word after reset", rd_data, 32'h0);

        // R3 R9 R2: table of writes and readbacks, pin held low
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][65:34]);
            chk("R9 readback", rd_data, VEC[i][33:2]);
            chk("R3 pin_oe", {31'b0, pin_oe}, {31'b0, VEC[i][1]});
            chk("R3 pin_out", {31'b0, pin_out}, {31'b0, VEC[i][0]});
        end

        // R2: synchronizer latency on the pin readback
        wr(32'h0);
        setpin(1'b1);
        cyc(1);
        chk("R2 pin not yet visible", rd_data[16] ? 32'h1 : 32'h0, 32'h0);
        cyc(1);
        chk("R2 pin visible", rd_data[16] ? 32'h1 : 32'h0, 32'h1);
        wr(32'h0);
        chk("R2 write bit16 ignored", rd_data, 32'h0001_0000);
        setpin(1'b0);
        cyc(3);

        // R4 rising edge, one-shot, sticky
        wr(DET | DLV | STS);
        setpin(1'b1);
        cyc(2);
        chk("R4 no early status", rd_data[28] ? 32'h1 : 32'h0, 32'h0);
        cyc(1);
        chk("R4 rising sets status", rd_data[28] ? 32'h1 : 32'h0, 32'h1);
        chk("R8 irq with both enables", {31'b0, irq}, 32'h1);
        wr(DET | DLV);
        chk("R7 write of zero keeps status", rd_data[28] ? 32'h1 : 32'h0, 32'h1);
        wr(DET | DLV | STS);
        chk("R7 clear", rd_data[28] ? 32'h1 : 32'h0, 32'h0);
        cyc(3);
        chk("R4 edge is one-shot", rd_data[28] ? 32'h1 : 32'h0, 32'h0);
        setpin(1'b0);
        cyc(3);
        chk("R4 fall ignored in rising mode", rd_data[28] ? 32'h1 : 32'h0, 32'h0);

        // R4 falling edge
        wr(DET | DLV | PLO | STS);
        setpin(1'b1);
        cyc(3);
        chk("R4 rise ignored in falling mode", rd_data[28] ? 32'h1 : 32'h0, 32'h0);
        setpin(1'b0);
        cyc(3);
        chk("R4 falling sets status", rd_data[28] ? 32'h1 : 32'h0, 32'h1);

        // R4 both edges, including polarity 11
        wr(DET | DLV | PBO | STS);
        setpin(1'b1);
        cyc(3);
        chk("R4 both: rise", rd_data[28] ? 32'h1 : 32'h0, 32'h1);
        wr(DET | DLV | PBO | STS);
        setpin(1'b0);
        cyc(3);
        chk("R4 both: fall", rd_data[28] ? 32'h1 : 32'h0, 32'h1);
        wr(DET | DLV | PBO | PLO | STS);
        chk("R9 polarity 11 readback", rd_data, DET | DLV | PBO | PLO);
        setpin(1'b1);
        cyc(3);
        chk("R4 polarity 11 acts as both", rd_data[28] ? 32'h1 : 32'h0, 32'h1);

        // R5 level high, re-arm after clear
        setpin(1'b0);
        cyc(3);
        wr(LVL | DET | DLV | STS);
        cyc(2);
        chk("R5 low level idle", rd_data[28] ? 32'h1 : 32'h0, 32'h0);
        setpin(1'b1);
        cyc(3);
        chk("R5 high level sets", rd_data[28] ? 32'h1 : 32'h0, 32'h1);
        wr(LVL | DET | DLV | STS);
        chk("R7 clear wins over held level", rd_data[28] ? 32'h1 : 32'h0, 32'h0);
        cyc(1);
        chk("R5 re-set after clear", rd_data[28] ? 32'h1 : 32'h0, 32'h1);
        setpin(1'b0);
        cyc(3);
        wr(LVL | DET | DLV | STS);
        cyc(2);
        chk("R5 stays clear when level gone", rd_data[28] ? 32'h1 : 32'h0, 32'h0);

        // R5 level low
        wr(LVL | PLO | DET | DLV | STS);
        chk("R5 low: cleared on write", rd_data[28] ? 32'h1 : 32'h0, 32'h0);
        cyc(1);
        chk("R5 low level sets", rd_data[28] ? 32'h1 : 32'h0, 32'h1);
        chk("R8 irq", {31'b0, irq}, 32'h1);

        // R6 R8 gating
        wr(LVL | PLO | DET);
        chk("R8 no delivery", {31'b0, irq}, 32'h0);
        chk("R8 status kept", rd_data[28] ? 32'h1 : 32'h0, 32'h1);
        wr(LVL | PLO | DLV);
        chk("R6 status held with detect off", rd_data[28] ? 32'h1 : 32'h0, 32'h1);
        chk("R8 no irq with detect off", {31'b0, irq}, 32'h0);
        wr(LVL | PLO | DLV | STS);
        cyc(3);
        chk("R6 no detection while disabled", rd_data[28] ? 32'h1 : 32'h0, 32'h0);
        wr(DLV);
        setpin(1'b1);
        cyc(3);
        chk("R6 edge ignored while disabled", rd_data[28] ? 32'h1 : 32'h0, 32'h0);

        // R5 level mode with both polarity: any level triggers
        wr(LVL | PBO | DET | STS);
        chk("R5 any-level cleared", rd_data[28] ? 32'h1 : 32'h0, 32'h0);
        cyc(1);
        chk("R5 any-level sets", rd_data[28] ? 32'h1 : 32'h0, 32'h1);
        chk("R8 no irq without delivery", {31'b0, irq}, 32'h0);
        wr(STS);
        chk("R8 masked cell quiet", {31'b0, irq}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule